// File: doc/BRIEF.md
# DMA Interrupt Pending and Service Controller

This block arbitrates the interrupts of a two-channel DMA engine. There are four interrupt sources: receive and transmit on channel A, and receive and transmit on channel B. Each source keeps three bits:

- a pending flag, set by a completion event, by an abort event or by a software command;
- an in-service flag, set when the processor acknowledges that source;
- an individual enable.

A source raises the shared request line only when all five of these hold: it is pending, it is individually enabled, the master enable is on, the daisy-chain input is high, and it is not already in service.

On acknowledge, the highest-priority requesting source moves from pending to in-service. A later command retires the highest in-service source. The block drives a daisy-chain output so that devices further down the chain stay quiet while this block is requesting or being served.

The block also holds the register that turns each DMA source on and enables the abort-interrupt condition of each source. Registers are read and written through a simple single-cycle port. Reads are combinational. Writes take effect at the next clock edge.

In every four-bit field, source order from the high bit down is: receive A, transmit A, receive B, transmit B. Receive A has the highest priority.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every register. After reset, all register reads return zero, `irq` is 0, `dma_chan_en` is 0 and `chain_out` equals `chain_in`.
- R2: The DMA-enable register is at address 5'b00100 and reads back what was written. Bits [7:4] are the per-source abort-interrupt enables and bits [3:0] are the per-source DMA enables, driven on `dma_chan_en`. Writes to other addresses do not change it.
- R3: The status register at address 5'b00101 reads {in-service[3:0], pending[3:0]}. Writes to it have no effect.
- R4: The interrupt-enable register is at address 5'b00110. Bit 7 is the master enable and bits [3:0] are the per-source enables. Bits [6:4] read as zero.
- R5: A high bit on `evt_done` sets that source's pending flag at the next clock edge.
- R6: A high bit on `evt_abort` sets that source's pending flag only when the matching abort enable (DMA-enable register bits [7:4]) is 1.
- R7: `cmd_op` 2'b01 sets the pending flags selected by `cmd_mask`, and 2'b10 clears them. 2'b00 changes nothing. Commands act only while `cmd_valid` is high.
- R8: When a pending flag is cleared by command or by acknowledge in the same cycle as an event on that source, the flag ends up set.
- R9: `irq` is high exactly when some source is pending, individually enabled and not in service, while the master enable and `chain_in` are both 1.
- R10: When `int_ack` is high, the highest-priority requesting source gets its in-service flag set and its pending flag cleared. Priority order is receive A, transmit A, receive B, transmit B. With no requesting source, `int_ack` changes nothing.
- R11: `cmd_op` 2'b11 clears only the highest-priority in-service flag that is set.
- R12: `chain_out` is 0 whenever `chain_in` is 0, any in-service flag is set, or `irq` is high. Otherwise it equals `chain_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Register address |
| reg_wdata | input | DATA_W (8) | Register write data |
| reg_rdata | output | DATA_W (8) | Combinational read data for `reg_addr` |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 set pending, 10 clear pending, 11 retire highest in-service |
| cmd_mask | input | NSRC (4) | Source select for set/clear commands |
| evt_done | input | NSRC (4) | Per-source interrupt condition pulses |
| evt_abort | input | NSRC (4) | Per-source abort condition pulses |
| int_ack | input | 1 | Interrupt acknowledge |
| chain_in | input | 1 | Daisy-chain enable from the upstream device |
| irq | output | 1 | Interrupt request |
| chain_out | output | 1 | Daisy-chain enable to the downstream device |
| dma_chan_en | output | NSRC (4) | Per-source DMA enables |

## Verification
The bench builds the block with its defaults: four sources, 8-bit data and 5-bit addresses. With only four sources, every combination can be swept in full.

- The request-gating sweep covers all 16 pending patterns, against all 16 enable masks, against both master-enable values and both chain-input values.
- The abort-gating sweep covers all 16 abort-enable masks against all 16 abort-event patterns.
- For every non-empty pending pattern, the bench runs one or two acknowledges followed by retire commands. These steps reach every priority pairing, the masking of an in-service source, and the chain output held low during service.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP     = 2'b00,
      CMD_SET_IP  = 2'b01,
      CMD_CLR_IP  = 2'b10,
      CMD_RST_IUS = 2'b11
   } cmd_op_e;

   localparam logic [4:0] ADDR_DMA_EN = 5'b00100;
   localparam logic [4:0] ADDR_STATUS = 5'b00101;
   localparam logic [4:0] ADDR_IRQ_EN = 5'b00110;

endpackage

// File: rtl/dma_irq_prio.sv
// Fixed-priority picker: the highest index wins. Output is one-hot or zero.
module dma_irq_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   always_comb begin
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_irq_src.sv
// One interrupt source: pending flag, in-service flag, request qualification.
module dma_irq_src (
   input  logic clk,
   input  logic rst,
   input  logic evt_done,
   input  logic evt_abort,
   input  logic abort_en,
   input  logic cmd_set,
   input  logic cmd_clr,
   input  logic ack_sel,
   input  logic ius_clr,
   input  logic src_ie,
   input  logic gate,
   output logic ip,
   output logic ius,
   output logic req
);

   logic set_any;
   logic clr_any;

   // Event sets are OR-ed in after the clears, so an event wins a same-cycle clear.
   assign set_any = evt_done | (evt_abort & abort_en) | cmd_set;
   assign clr_any = cmd_clr | ack_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         ip  <= 1'b0;
         ius <= 1'b0;
      end else begin
         ip  <= (ip & ~clr_any) | set_any;
         ius <= (ius & ~ius_clr) | ack_sel;
      end
   end

   assign req = ip & src_ie & gate & ~ius;

endmodule

// File: rtl/dma_irq_regs.sv
// Software-visible registers: DMA enables, abort enables, interrupt enables, status.
module dma_irq_regs
   import dma_irq_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int DATA_W = 8,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NSRC-1:0]   ip,
   input  logic [NSRC-1:0]   ius,
   output logic [DATA_W-1:0] rdata,
   output logic [NSRC-1:0]   chan_en,
   output logic [NSRC-1:0]   abort_en,
   output logic [NSRC-1:0]   src_ie,
   output logic              mie
);

   localparam logic [AW-1:0] A_DMA_EN = AW'(ADDR_DMA_EN);
   localparam logic [AW-1:0] A_STATUS = AW'(ADDR_STATUS);
   localparam logic [AW-1:0] A_IRQ_EN = AW'(ADDR_IRQ_EN);

   logic [DATA_W-1:0] dmaen_q;
   logic [NSRC-1:0]   ie_q;
   logic              mie_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dmaen_q <= '0;
         ie_q    <= '0;
         mie_q   <= 1'b0;
      end else if (wr_en) begin
         if (addr == A_DMA_EN) dmaen_q <= wdata;
         if (addr == A_IRQ_EN) begin
            ie_q  <= wdata[NSRC-1:0];
            mie_q <= wdata[DATA_W-1];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_DMA_EN: rdata = dmaen_q;
         A_STATUS: rdata = {ius, ip};
         A_IRQ_EN: begin
            rdata[DATA_W-1] = mie_q;
            rdata[NSRC-1:0] = ie_q;
         end
         default:  rdata = '0;
      endcase
   end

   assign chan_en  = dmaen_q[NSRC-1:0];
   assign abort_en = dmaen_q[DATA_W-1:NSRC];
   assign src_ie   = ie_q;
   assign mie      = mie_q;

endmodule

// File: rtl/dma_irq_ctrl.sv
// Four-source DMA interrupt controller with acknowledge and daisy chain.
module dma_irq_ctrl
   import dma_irq_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int DATA_W = 8,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [NSRC-1:0]   cmd_mask,
   input  logic [NSRC-1:0]   evt_done,
   input  logic [NSRC-1:0]   evt_abort,
   input  logic              int_ack,
   input  logic              chain_in,
   output logic              irq,
   output logic              chain_out,
   output logic [NSRC-1:0]   dma_chan_en
);

   generate
      if (NSRC < 2) begin : g_bad_nsrc
         $error("dma_irq_ctrl: NSRC must be at least 2");
      end
      if (DATA_W != 2 * NSRC) begin : g_bad_width
         $error("dma_irq_ctrl: DATA_W must equal 2*NSRC");
      end
      if (AW < 3) begin : g_bad_aw
         $error("dma_irq_ctrl: AW must be at least 3");
      end
   endgenerate

   cmd_op_e         op;
   logic [NSRC-1:0] cmd_set;
   logic [NSRC-1:0] cmd_clr;
   logic            rst_ius;
   logic [NSRC-1:0] ip_vec;
   logic [NSRC-1:0] ius_vec;
   logic [NSRC-1:0] req_vec;
   logic [NSRC-1:0] ack_grant;
   logic [NSRC-1:0] ius_top;
   logic [NSRC-1:0] ack_sel;
   logic [NSRC-1:0] ius_clr;
   logic [NSRC-1:0] abort_en;
   logic [NSRC-1:0] src_ie;
   logic            mie;
   logic            gate;

   assign op      = cmd_op_e'(cmd_op);
   assign cmd_set = (cmd_valid && op == CMD_SET_IP) ? cmd_mask : '0;
   assign cmd_clr = (cmd_valid && op == CMD_CLR_IP) ? cmd_mask : '0;
   assign rst_ius = cmd_valid && op == CMD_RST_IUS;

   dma_irq_regs #(
      .NSRC   (NSRC),
      .DATA_W (DATA_W),
      .AW     (AW)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .ip       (ip_vec),
      .ius      (ius_vec),
      .rdata    (reg_rdata),
      .chan_en  (dma_chan_en),
      .abort_en (abort_en),
      .src_ie   (src_ie),
      .mie      (mie)
   );

   dma_irq_prio #(.N(NSRC)) u_ack_pick (.req(req_vec), .grant(ack_grant));
   dma_irq_prio #(.N(NSRC)) u_ius_pick (.req(ius_vec), .grant(ius_top));

   assign ack_sel = int_ack ? ack_grant : '0;
   assign ius_clr = rst_ius ? ius_top : '0;
   assign gate    = mie & chain_in;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         dma_irq_src u_src (
            .clk       (clk),
            .rst       (rst),
            .evt_done  (evt_done[g]),
            .evt_abort (evt_abort[g]),
            .abort_en  (abort_en[g]),
            .cmd_set   (cmd_set[g]),
            .cmd_clr   (cmd_clr[g]),
            .ack_sel   (ack_sel[g]),
            .ius_clr   (ius_clr[g]),
            .src_ie    (src_ie[g]),
            .gate      (gate),
            .ip        (ip_vec[g]),
            .ius       (ius_vec[g]),
            .req       (req_vec[g])
         );
      end
   endgenerate

   assign irq       = |req_vec;
   assign chain_out = chain_in & ~(|ius_vec) & ~(|req_vec);

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
   import dma_irq_pkg::*;
#(
   parameter int NSRC = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            irq,
   input logic            chain_in,
   input logic            chain_out,
   input logic            int_ack,
   input logic            cmd_valid,
   input logic [1:0]      cmd_op,
   input logic [NSRC-1:0] evt_done,
   input logic [NSRC-1:0] evt_abort,
   input logic [NSRC-1:0] abort_en,
   input logic [NSRC-1:0] ip,
   input logic [NSRC-1:0] ius
);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ip == '0 && ius == '0));

   assert_event_sets_ip_R5: assert property (@(posedge clk) disable iff (rst)
      (evt_done != '0) |=> ((ip & $past(evt_done)) == $past(evt_done)));

   assert_no_spurious_ip_R6: assert property (@(posedge clk) disable iff (rst)
      (!(cmd_valid && cmd_op == CMD_SET_IP) && evt_done == '0 && (evt_abort & abort_en) == '0)
      |=> ((ip & ~$past(ip)) == '0));

   assert_irq_needs_chain_R9: assert property (@(posedge clk) disable iff (rst)
      irq |-> chain_in);

   assert_ack_takes_service_R10: assert property (@(posedge clk) disable iff (rst)
      (int_ack && irq && !(cmd_valid && cmd_op == CMD_RST_IUS))
      |=> ($countones(ius) == $countones($past(ius)) + 1));

   assert_retire_one_R11: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == CMD_RST_IUS && !int_ack && ius != '0)
      |=> ($countones(ius) + 1 == $countones($past(ius))));

   assert_chain_blocked_R12: assert property (@(posedge clk) disable iff (rst)
      (ius != '0 || irq || !chain_in) |-> !chain_out);

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .irq       (irq),
   .chain_in  (chain_in),
   .chain_out (chain_out),
   .int_ack   (int_ack),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .evt_done  (evt_done),
   .evt_abort (evt_abort),
   .abort_en  (abort_en),
   .ip        (ip_vec),
   .ius       (ius_vec)
);

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 4;
   localparam int DW   = 8;
   localparam int AW   = 5;

   localparam logic [AW-1:0] A_DMAEN  = 5'b00100;
   localparam logic [AW-1:0] A_STATUS = 5'b00101;
   localparam logic [AW-1:0] A_IEN    = 5'b00110;

   logic            clk = 1'b0;
   logic            rst;
   logic            reg_wr;
   logic [AW-1:0]   reg_addr;
   logic [DW-1:0]   reg_wdata;
   logic [DW-1:0]   reg_rdata;
   logic            cmd_valid;
   logic [1:0]      cmd_op;
   logic [NSRC-1:0] cmd_mask;
   logic [NSRC-1:0] evt_done;
   logic [NSRC-1:0] evt_abort;
   logic            int_ack;
   logic            chain_in;
   logic            irq;
   logic            chain_out;
   logic [NSRC-1:0] dma_chan_en;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_irq_ctrl #(.NSRC(NSRC), .DATA_W(DW), .AW(AW)) uut (
      .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cmd_valid (cmd_valid),
      .cmd_op (cmd_op), .cmd_mask (cmd_mask), .evt_done (evt_done),
      .evt_abort (evt_abort), .int_ack (int_ack), .chain_in (chain_in),
      .irq (irq), .chain_out (chain_out), .dma_chan_en (dma_chan_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      step();
      reg_wr    = 1'b0;
   endtask

   task automatic command(input logic [1:0] op, input logic [NSRC-1:0] m);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_mask  = m;
      step();
      cmd_valid = 1'b0;
      cmd_op    = 2'b00;
      cmd_mask  = '0;
   endtask

   task automatic clear_all();
      command(2'b10, 4'hF);
      for (int k = 0; k < NSRC; k++) command(2'b11, 4'h0);
   endtask

   task automatic acknowledge();
      int_ack = 1'b1;
      step();
      int_ack = 1'b0;
   endtask

   function automatic logic [NSRC-1:0] top_bit(input logic [NSRC-1:0] v);
      logic [NSRC-1:0] r = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (v[i] && r == '0) r[i] = 1'b1;
      end
      return r;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      cmd_valid = 1'b0; cmd_op = 2'b00; cmd_mask = '0;
      evt_done = '0; evt_abort = '0; int_ack = 1'b0; chain_in = 1'b1;
      repeat (3) step();
      rst = 1'b0;

      // R1: reset state
      rd(A_STATUS, d); check("R1 status", d, 8'h00);
      rd(A_DMAEN, d);  check("R1 dmaen", d, 8'h00);
      rd(A_IEN, d);    check("R1 ien", d, 8'h00);
      check("R1 irq", irq, 0);
      check("R1 chan_en", dma_chan_en, 0);
      check("R1 chain_out", chain_out, 1);

      // R2: DMA enable register
      wr(A_DMAEN, 8'hA5);
      rd(A_DMAEN, d); check("R2 readback", d, 8'hA5);
      check("R2 chan_en", dma_chan_en, 4'h5);
      wr(5'b00000, 8'hFF);
      rd(A_DMAEN, d); check("R2 other addr", d, 8'hA5);
      wr(A_DMAEN, 8'h5A);
      check("R2 chan_en 2", dma_chan_en, 4'hA);

      // R3: status is read-only
      wr(A_STATUS, 8'hFF);
      rd(A_STATUS, d); check("R3 write ignored", d, 8'h00);

      // R4: interrupt enable layout
      wr(A_IEN, 8'hFF);
      rd(A_IEN, d); check("R4 readback", d, 8'h8F);
      wr(A_IEN, 8'h00);

      // R5: completion events set pending flags
      for (int p = 1; p < 16; p++) begin
         clear_all();
         evt_done = p[3:0];
         step();
         evt_done = '0;
         rd(A_STATUS, d); check("R5 event sets ip", d, {4'h0, p[3:0]});
      end

      // R6: abort events gated by abort enables
      for (int ae = 0; ae < 16; ae++) begin
         wr(A_DMAEN, {ae[3:0], 4'h0});
         for (int ev = 0; ev < 16; ev++) begin
            clear_all();
            evt_abort = ev[3:0];
            step();
            evt_abort = '0;
            rd(A_STATUS, d); check("R6 abort gating", d, {4'h0, ae[3:0] & ev[3:0]});
         end
      end
      wr(A_DMAEN, 8'h00);

      // R7: set/clear/no-op commands
      clear_all();
      command(2'b01, 4'b1010);
      rd(A_STATUS, d); check("R7 set", d, 8'h0A);
      command(2'b00, 4'hF);
      rd(A_STATUS, d); check("R7 nop", d, 8'h0A);
      cmd_op = 2'b10; cmd_mask = 4'hF; step(); cmd_op = 2'b00; cmd_mask = '0;
      rd(A_STATUS, d); check("R7 no valid", d, 8'h0A);
      command(2'b01, 4'b0101);
      rd(A_STATUS, d); check("R7 set 2", d, 8'h0F);
      command(2'b10, 4'b0011);
      rd(A_STATUS, d); check("R7 clear", d, 8'h0C);

      // R8: event beats clear in the same cycle
      evt_done = 4'b0100;
      command(2'b10, 4'hF);
      evt_done = '0;
      rd(A_STATUS, d); check("R8 event wins", d, 8'h04);

      // R9 and R12: full sweep of request gating
      for (int m = 0; m < 2; m++) begin
         for (int ie = 0; ie < 16; ie++) begin
            wr(A_IEN, {m[0], 3'b000, ie[3:0]});
            for (int p = 0; p < 16; p++) begin
               clear_all();
               command(2'b01, p[3:0]);
               for (int c = 0; c < 2; c++) begin
                  logic exp_irq;
                  chain_in = c[0];
                  #1;
                  exp_irq = (|(p[3:0] & ie[3:0])) & m[0] & c[0];
                  check("R9 irq gating", irq, exp_irq);
                  check("R12 chain_out", chain_out, c[0] & ~exp_irq);
               end
            end
         end
      end
      chain_in = 1'b1;

      // R10: acknowledge with no request changes nothing
      wr(A_IEN, 8'h8F);
      clear_all();
      acknowledge();
      rd(A_STATUS, d); check("R10 ack idle", d, 8'h00);
      wr(A_IEN, 8'h0F);
      command(2'b01, 4'h3);
      acknowledge();
      rd(A_STATUS, d); check("R10 ack masked", d, 8'h03);
      wr(A_IEN, 8'h8F);

      // R10, R11, R12: acknowledge and retire sweep
      for (int p = 1; p < 16; p++) begin
         logic [3:0] h1, h2, rest;
         clear_all();
         command(2'b01, p[3:0]);
         h1 = top_bit(p[3:0]);
         rest = p[3:0] & ~h1;
         acknowledge();
         rd(A_STATUS, d); check("R10 ack picks top", d, {h1, rest});
         check("R9 irq after ack", irq, |rest);
         check("R12 chain low in service", chain_out, 0);
         if (rest == '0) begin
            command(2'b01, p[3:0]);
            check("R9 in-service masks", irq, 0);
            command(2'b11, 4'h0);
            rd(A_STATUS, d); check("R11 retire single", d, {4'h0, p[3:0]});
            check("R9 request after retire", irq, 1);
         end else begin
            h2 = top_bit(rest);
            acknowledge();
            rd(A_STATUS, d); check("R10 second ack", d, {h1 | h2, rest & ~h2});
            command(2'b11, 4'h0);
            rd(A_STATUS, d); check("R11 retire top", d, {h2, rest & ~h2});
            command(2'b11, 4'h0);
            rd(A_STATUS, d); check("R11 retire next", d, {4'h0, rest & ~h2});
         end
      end

      summary();
      $finish;
   end

endmodule